// File: doc/BRIEF.md
# PHY Management Register File

This block holds the management register set of a 10/100 Ethernet PHY as a station manager sees it after the serial management framing has been stripped off. A requester presents a 5-bit PHY address, a 5-bit register index and either a read or a write strobe with 16 bits of data. Only accesses whose PHY address equals the strapped address of this PHY reach the registers; all others read as all ones and never change state.

The control and advertisement words are the only stored, writable state. The status word and the link-partner ability word are derived from a registered copy of the link-up input, so a link change is reflected without any software action. Setting the top bit in a control write performs a soft reset of the register set instead of storing the value. Two identifier words are fixed by parameters, and the expansion index and every index above it read as zero.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset, index 0 (control) reads 0x3100 (speed select bit 13, autonegotiation enable bit 12, full duplex bit 8) and index 4 (advertisement) reads 0x01E1 (bits 8, 7, 6, 5 and selector value 1).
- R2: Index 1 (status) reads 0x7848 while the tracked link is down and 0x786C while it is up (link status bit 2 and autonegotiation complete bit 5 added).
- R3: Index 5 (partner ability) reads 0x0080 while the tracked link is down and 0x01E1 while it is up.
- R4: The link-up input is sampled on every clock edge with no reset needed; a read accepted on any edge after the one that sampled a new level returns status and partner words for that level.
- R5: A read whose PHY address differs from phy_addr_strap returns 0xFFFF, and a write to such an address changes no register.
- R6: A write to index 0 with bit 15 clear stores all 16 bits of the data; a write to index 4 stores all 16 bits.
- R7: A write to index 0 with bit 15 set restores the control and advertisement words to their R1 values and does not store the written data.
- R8: Writes to indices 1, 2, 3, 5, 6 and 7 to 31 are ignored: control, advertisement and every readable word keep their values.
- R9: Index 6 and indices 7 to 31 read 0x0000.
- R10: Index 2 reads parameter ID_HI (default 0x0000) and index 3 reads ID_LO (default 0x8201).
- R11: rd_valid is high exactly in the cycle after a read strobe, and rd_data then holds the read result until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr_strap | input | 5 | Address this PHY answers to |
| acc_phy | input | 5 | PHY address of the current access |
| acc_reg | input | 5 | Register index of the current access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 16 | Write data |
| link_up | input | 1 | Line link indication |
| rd_data | output | 16 | Read result, registered |
| rd_valid | output | 1 | Read result valid pulse |

## Verification
A corrupted control or advertisement word shows up at the next read of index 0 or 4, one cycle after that read's strobe, and never otherwise, so the stimulus interleaves writes with frequent reads of every index. A stale or missed link sample appears in the status and partner words on the first read after the link input moves, which is why the link toggles between accesses at random. A wrong address match shows as a missing 0xFFFF or as a write from a foreign address leaking into a later read of the matching PHY.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int unsigned DW = 16;

  localparam int unsigned IDX_CTRL    = 0;
  localparam int unsigned IDX_STAT    = 1;
  localparam int unsigned IDX_ID_HI   = 2;
  localparam int unsigned IDX_ID_LO   = 3;
  localparam int unsigned IDX_ADV     = 4;
  localparam int unsigned IDX_PARTNER = 5;
  localparam int unsigned IDX_EXP     = 6;
  localparam int unsigned NUM_IDX     = 7;

  localparam int unsigned CTRL_SOFT_RST_BIT = 15;

  localparam logic [DW-1:0] CTRL_DEF  = 16'h3100;
  localparam logic [DW-1:0] ADV_DEF   = 16'h01E1;
  localparam logic [DW-1:0] STAT_BASE = 16'h7848;
  localparam logic [DW-1:0] STAT_LINK = 16'h0024;
  localparam logic [DW-1:0] ABIL_100TX = 16'h0080;
  localparam logic [DW-1:0] ABIL_LINKED = 16'h0161;
  localparam logic [DW-1:0] NO_PHY    = 16'hFFFF;

  function automatic logic [DW-1:0] status_word(input logic lnk);
    return lnk ? (STAT_BASE | STAT_LINK) : STAT_BASE;
  endfunction

  function automatic logic [DW-1:0] partner_word(input logic lnk);
    return lnk ? (ABIL_100TX | ABIL_LINKED) : ABIL_100TX;
  endfunction

endpackage

// File: rtl/phy_access_decode.sv
module phy_access_decode #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned NSEL   = 7
) (
  input  logic [ADDR_W-1:0] phy_addr_strap,
  input  logic [ADDR_W-1:0] acc_phy,
  input  logic [REG_W-1:0]  acc_reg,
  output logic              addr_hit,
  output logic [NSEL-1:0]   sel
);
  assign addr_hit = (acc_phy == phy_addr_strap);

  for (genvar i = 0; i < NSEL; i++) begin : g_sel
    assign sel[i] = addr_hit && (acc_reg == REG_W'(i));
  end
endmodule

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs
  import phy_mgmt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          sel_ctrl,
  input  logic          sel_adv,
  input  logic [DW-1:0] wr_data,
  output logic          soft_rst_evt,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] adv_q
);
  logic ctrl_wr;
  logic adv_wr;

  assign soft_rst_evt = wr_en && sel_ctrl && wr_data[CTRL_SOFT_RST_BIT];
  assign ctrl_wr      = wr_en && sel_ctrl && !wr_data[CTRL_SOFT_RST_BIT];
  assign adv_wr       = wr_en && sel_adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_DEF;
      adv_q  <= ADV_DEF;
    end else if (soft_rst_evt) begin
      ctrl_q <= CTRL_DEF;
      adv_q  <= ADV_DEF;
    end else begin
      if (ctrl_wr) ctrl_q <= wr_data;
      if (adv_wr)  adv_q  <= wr_data;
    end
  end
endmodule

// File: rtl/phy_link_track.sv
module phy_link_track
  import phy_mgmt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_up,
  output logic          link_q,
  output logic [DW-1:0] status_w,
  output logic [DW-1:0] partner_w
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_up;
  end

  assign status_w  = status_word(link_q);
  assign partner_w = partner_word(link_q);
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned     ADDR_W = 5,
  parameter int unsigned     REG_W  = 5,
  parameter logic [DW-1:0]   ID_HI  = 16'h0000,
  parameter logic [DW-1:0]   ID_LO  = 16'h8201
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] phy_addr_strap,
  input  logic [ADDR_W-1:0] acc_phy,
  input  logic [REG_W-1:0]  acc_reg,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              link_up,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid
);
  logic               addr_hit;
  logic [NUM_IDX-1:0] sel;
  logic               soft_rst_evt;
  logic [DW-1:0]      ctrl_q;
  logic [DW-1:0]      adv_q;
  logic               link_q;
  logic [DW-1:0]      status_w;
  logic [DW-1:0]      partner_w;
  logic [DW-1:0]      rd_mux;

  phy_access_decode #(.ADDR_W(ADDR_W), .REG_W(REG_W), .NSEL(NUM_IDX)) u_dec (
    .phy_addr_strap (phy_addr_strap),
    .acc_phy        (acc_phy),
    .acc_reg        (acc_reg),
    .addr_hit       (addr_hit),
    .sel            (sel)
  );

  phy_ctrl_regs u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .sel_ctrl     (sel[IDX_CTRL]),
    .sel_adv      (sel[IDX_ADV]),
    .wr_data      (wr_data),
    .soft_rst_evt (soft_rst_evt),
    .ctrl_q       (ctrl_q),
    .adv_q        (adv_q)
  );

  phy_link_track u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_up   (link_up),
    .link_q    (link_q),
    .status_w  (status_w),
    .partner_w (partner_w)
  );

  always_comb begin
    rd_mux = '0;
    if (!addr_hit)              rd_mux = NO_PHY;
    else if (sel[IDX_CTRL])     rd_mux = ctrl_q;
    else if (sel[IDX_STAT])     rd_mux = status_w;
    else if (sel[IDX_ID_HI])    rd_mux = ID_HI;
    else if (sel[IDX_ID_LO])    rd_mux = ID_LO;
    else if (sel[IDX_ADV])      rd_mux = adv_q;
    else if (sel[IDX_PARTNER])  rd_mux = partner_w;
    else if (sel[IDX_EXP])      rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned REG_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] phy_addr_strap,
  input logic [ADDR_W-1:0] acc_phy,
  input logic [REG_W-1:0]  acc_reg,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DW-1:0]     wr_data,
  input logic              link_up,
  input logic [DW-1:0]     rd_data,
  input logic              rd_valid,
  input logic [DW-1:0]     ctrl_q,
  input logic [DW-1:0]     adv_q,
  input logic              link_q
);
  // R11
  rd_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R11
  rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R5
  foreign_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && acc_phy != phy_addr_strap) |=> rd_data == NO_PHY);

  // R5
  foreign_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_phy != phy_addr_strap) |=> ($stable(ctrl_q) && $stable(adv_q)));

  // R7
  soft_reset_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_phy == phy_addr_strap && acc_reg == '0 && wr_data[CTRL_SOFT_RST_BIT])
    |=> (ctrl_q == CTRL_DEF && adv_q == ADV_DEF));

  // R8
  ro_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_reg != REG_W'(IDX_CTRL) && acc_reg != REG_W'(IDX_ADV))
    |=> ($stable(ctrl_q) && $stable(adv_q)));

  // R4
  link_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> link_q == $past(link_up));

  // R2
  status_link_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && acc_phy == phy_addr_strap && acc_reg == REG_W'(IDX_STAT))
    |=> (rd_data[2] == $past(link_q) && rd_data[5] == $past(link_q)));
endmodule

bind phy_mgmt_regfile phy_mgmt_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .phy_addr_strap (phy_addr_strap),
  .acc_phy        (acc_phy),
  .acc_reg        (acc_reg),
  .wr_en          (wr_en),
  .rd_en          (rd_en),
  .wr_data        (wr_data),
  .link_up        (link_up),
  .rd_data        (rd_data),
  .rd_valid       (rd_valid),
  .ctrl_q         (ctrl_q),
  .adv_q          (adv_q),
  .link_q         (link_q)
);

// File: tb/sim_phy_mgmt_regfile.sv
`timescale 1ns/1ps
module sim_phy_mgmt_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  phy_addr_strap = 5'd3;
  logic [4:0]  acc_phy = '0;
  logic [4:0]  acc_reg = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        link_up = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] m_ctrl;
  logic [15:0] m_adv;
  logic        m_link;

  always #2.5 clk = ~clk;

  phy_mgmt_regfile u0 (
    .clk(clk), .rst_n(rst_n), .phy_addr_strap(phy_addr_strap),
    .acc_phy(acc_phy), .acc_reg(acc_reg), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .link_up(link_up), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // Expected read value restated from the requirements
  function automatic logic [15:0] exp_read(input logic [4:0] phy, input logic [4:0] idx);
    if (phy != phy_addr_strap) return 16'hFFFF;          // R5
    case (idx)
      5'd0: return m_ctrl;                                // R1 R6 R7
      5'd1: return m_link ? 16'h786C : 16'h7848;          // R2
      5'd2: return 16'h0000;                              // R10
      5'd3: return 16'h8201;                              // R10
      5'd4: return m_adv;                                 // R1 R6 R7
      5'd5: return m_link ? 16'h01E1 : 16'h0080;          // R3
      default: return 16'h0000;                           // R9
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] phy, input logic [4:0] idx);
    if (phy != phy_addr_strap) return "R5";
    case (idx)
      5'd0, 5'd4: return "R6";
      5'd1: return "R2";
      5'd2, 5'd3: return "R10";
      5'd5: return "R3";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [4:0] phy, input logic [4:0] idx, input logic [15:0] d);
    @(negedge clk);
    acc_phy = phy; acc_reg = idx; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (phy == phy_addr_strap) begin
      if (idx == 5'd0) begin
        if (d[15]) begin m_ctrl = 16'h3100; m_adv = 16'h01E1; end
        else m_ctrl = d;
      end else if (idx == 5'd4) m_adv = d;
    end
  endtask

  task automatic do_read(input logic [4:0] phy, input logic [4:0] idx, input string req);
    logic [15:0] e;
    @(negedge clk);
    acc_phy = phy; acc_reg = idx; rd_en = 1'b1;
    e = exp_read(phy, idx);
    @(negedge clk);
    rd_en = 1'b0;
    check("R11", {15'd0, rd_valid}, 16'd1);
    check(req, rd_data, e);
  endtask

  task automatic set_link(input logic l);
    @(negedge clk);
    link_up = l;
    m_link = l;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    m_ctrl = 16'h3100; m_adv = 16'h01E1; m_link = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", {15'd0, rd_valid}, 16'd0);

    // R1 reset defaults
    do_read(5'd3, 5'd0, "R1");
    do_read(5'd3, 5'd4, "R1");
    // R2 R3 link down
    do_read(5'd3, 5'd1, "R2");
    do_read(5'd3, 5'd5, "R3");
    // R10 identifiers
    do_read(5'd3, 5'd2, "R10");
    do_read(5'd3, 5'd3, "R10");
    // R9 expansion and beyond
    do_read(5'd3, 5'd6, "R9");
    do_read(5'd3, 5'd31, "R9");
    // R4 link up then down
    set_link(1'b1);
    do_read(5'd3, 5'd1, "R4");
    do_read(5'd3, 5'd5, "R4");
    set_link(1'b0);
    do_read(5'd3, 5'd1, "R4");
    do_read(5'd3, 5'd5, "R4");
    set_link(1'b1);
    // R6 writes
    do_write(5'd3, 5'd0, 16'h7FFF);
    do_read(5'd3, 5'd0, "R6");
    do_write(5'd3, 5'd4, 16'hBEEF);
    do_read(5'd3, 5'd4, "R6");
    // R5 foreign address
    do_write(5'd9, 5'd0, 16'h0000);
    do_write(5'd9, 5'd4, 16'h0000);
    do_read(5'd3, 5'd0, "R5");
    do_read(5'd3, 5'd4, "R5");
    do_read(5'd9, 5'd0, "R5");
    // R8 read-only indices
    do_write(5'd3, 5'd1, 16'h0000);
    do_write(5'd3, 5'd2, 16'hFFFF);
    do_write(5'd3, 5'd5, 16'h0000);
    do_write(5'd3, 5'd6, 16'h1234);
    do_write(5'd3, 5'd20, 16'h1234);
    do_read(5'd3, 5'd0, "R8");
    do_read(5'd3, 5'd4, "R8");
    do_read(5'd3, 5'd1, "R8");
    do_read(5'd3, 5'd2, "R8");
    do_read(5'd3, 5'd5, "R8");
    do_read(5'd3, 5'd6, "R8");
    // R7 soft reset, value not stored
    do_write(5'd3, 5'd0, 16'hFFFF);
    do_read(5'd3, 5'd0, "R7");
    do_read(5'd3, 5'd4, "R7");
    do_read(5'd3, 5'd1, "R7");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [4:0] p;
      logic [4:0] r;
      logic [15:0] d;
      int op;
      p = ($urandom % 2 == 0) ? phy_addr_strap : 5'($urandom % 32);
      r = ($urandom % 4 == 0) ? 5'($urandom % 32) : 5'($urandom % 8);
      d = 16'($urandom);
      op = $urandom % 10;
      if (op < 4) do_write(p, r, d);
      else if (op < 9) do_read(p, r, tag_of(p, r));
      else set_link(~m_link);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule